// File: doc/BRIEF.md
# Descriptor-Driven Frame Receive Engine

This block takes frames arriving one byte per beat on a stream with an end-of-frame marker, an error marker and sideband metadata: the receiving port number and a timestamp with its qualifiers. When a frame starts, the block looks for a free receive descriptor. A descriptor is free when its empty bit is set. The frame bytes go straight into packet RAM, starting at the buffer offset named in that descriptor. On the last beat the block writes back into the descriptor the number of bytes stored, the port, the error state and the timestamp, and clears the empty bit. This hands the descriptor back to software, which must set the empty bit again before the descriptor can be reused.

Software loads and inspects the descriptor table through a plain word-wide write and read port. Completion raises a sticky frame-received status flag and a level interrupt, and each has its own clear input. A frame that finds no free descriptor is discarded and raises a sticky buffer-not-available flag. A frame that starts while receive is disabled is ignored entirely.

Top module: `rx_desc_engine`

## Requirements
- R1: After reset, st_rec, st_bna and irq_rx are 0, cur_desc is 0, ram_we is 0, and every descriptor word reads 0, so no descriptor is free.
- R2: At the first beat of a frame, the engine takes the first free descriptor (word 0 bit 0 = 1) found in round-robin order. The search starts at the index after the descriptor taken last, or at index 0 after reset, and wraps past the last index. Descriptors whose empty bit is 0 are skipped.
- R3: Each stored byte is written in the same cycle as its beat. ram_we is 1, ram_wdata is the beat's byte, and ram_addr is the descriptor offset (word 2 bits 15:0) with bits 1:0 forced to 0, plus the byte's index within the frame.
- R4: When the last beat is accepted, the descriptor's word 0 bit 0 (empty) becomes 0 and word 2 bits 31:16 become the number of bytes stored. Word 2 bits 15:0 (offset) are left unchanged.
- R5: The write-back stores the sideband values present on the last beat. The port goes to word 0 bits 13:8, the timestamp-valid bit to word 0 bit 14, and the timestamp-suspect bit to word 0 bit 15. The 28 rising-edge timestamp bits go to word 1 bits 27:0 and the 4 falling-edge bits to word 1 bits 31:28.
- R6: Word 0 bit 1 (error) is written as 1 if in_err was 1 on any beat of the frame, and as 0 otherwise.
- R7: When a frame is longer than the buffer size (word 2 bits 31:16 at frame start), only the first buffer-size bytes are written to RAM. The stored length equals the buffer size, and the error bit is set.
- R8: A frame that finds no free descriptor while receive is enabled causes no RAM write and no descriptor change. It sets st_bna, which stays at 1 until a bna_clr pulse.
- R9: st_rec becomes 1 in the cycle after a frame's last beat is stored, and stays at 1 until a rec_clr pulse.
- R10: irq_rx is an active-high level that becomes 1 together with st_rec and stays at 1 until an irq_ack pulse, independent of rec_clr.
- R11: A frame whose first beat arrives while rx_enable is 0 is ignored in full. It causes no RAM write, no descriptor change, and no change to st_rec, st_bna, irq_rx or cur_desc.
- R12: cur_desc holds the index of the descriptor taken by the most recent accepted frame, updated in the cycle after that frame's first beat.
- R13: A descriptor that has been written back is not taken again until software sets its empty bit back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receive enable, sampled at the first beat of each frame |
| in_valid | input | 1 | Beat valid |
| in_data | input | 8 | Beat byte |
| in_last | input | 1 | Last beat of frame |
| in_err | input | 1 | Upstream marks the frame as errored |
| in_port | input | 6 | Receiving port number (sampled on last beat) |
| in_ts_valid | input | 1 | Timestamp present |
| in_ts_bad | input | 1 | Timestamp taken during counter adjustment |
| in_ts_rise | input | 28 | Rising-edge timestamp bits |
| in_ts_fall | input | 4 | Falling-edge timestamp bits |
| ram_we | output | 1 | Packet RAM byte write strobe |
| ram_addr | output | 16 | Packet RAM byte address |
| ram_wdata | output | 8 | Packet RAM write byte |
| sw_we | input | 1 | Descriptor word write strobe |
| sw_idx | input | 3 | Descriptor index for writes |
| sw_word | input | 2 | Word select for writes (0 status, 1 timestamp, 2 buffer) |
| sw_wdata | input | 32 | Descriptor write data |
| sw_rd_idx | input | 3 | Descriptor index for reads |
| sw_rd_word | input | 2 | Word select for reads (3 reads 0) |
| sw_rd_data | output | 32 | Descriptor read data, combinational |
| rec_clr | input | 1 | Clears st_rec |
| bna_clr | input | 1 | Clears st_bna |
| irq_ack | input | 1 | Acknowledges irq_rx |
| st_rec | output | 1 | Frame-received status |
| st_bna | output | 1 | Buffer-not-available status |
| irq_rx | output | 1 | Receive-complete interrupt level |
| cur_desc | output | 3 | Index of descriptor taken last |

## Verification
The round-robin wrap together with the skip over non-free slots is the hardest situation to reach from the ports. It needs a search pointer sitting near the top of the table while only a low-index descriptor is free. The stimulus first consumes a sparse set of free descriptors (0, 1, 2, then 5 with 3 and 4 held busy). This exhausts the table, so that a frame is dropped with buffer-not-available. It then re-arms only descriptor 0, so that the next frame, a single-beat one, must wrap from index 6 back to 0. A scoreboard compares every RAM byte write against the expected address and data, which also shows that dropped and disabled frames write nothing.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   typedef enum logic [1:0] {S_IDLE, S_FILL, S_DROP} rx_state_t;
   // word 0 bit positions
   localparam int W0_EMPTY = 0;
   localparam int W0_ERR   = 1;
   localparam int W0_PORT  = 8;
   localparam int W0_GOTTS = 14;
   localparam int W0_TSBAD = 15;
   // word select codes
   localparam logic [1:0] WSEL_STAT = 2'd0;
   localparam logic [1:0] WSEL_TS   = 2'd1;
   localparam logic [1:0] WSEL_BUF  = 2'd2;
endpackage

// File: rtl/rxd_flag.sv
module rxd_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/rxd_pick.sv
module rxd_pick #(
   parameter int NDESC = 8,
   localparam int IDXW = $clog2(NDESC)
) (
   input  logic [NDESC-1:0] avail_i,
   input  logic [IDXW-1:0]  base_i,
   output logic             found_o,
   output logic [IDXW-1:0]  idx_o
);
   logic [2*NDESC-1:0] dbl;
   logic [NDESC-1:0]   rot;
   logic [IDXW-1:0]    ofs;

   assign dbl = {avail_i, avail_i} >> base_i;
   assign rot = dbl[NDESC-1:0];

   always_comb begin
      ofs = '0;
      for (int k = NDESC - 1; k >= 0; k--)
         if (rot[k]) ofs = IDXW'(k);
   end
   assign found_o = |avail_i;

   generate
      if ((NDESC & (NDESC - 1)) == 0) begin : g_pow2
         assign idx_o = base_i + ofs;
      end else begin : g_mod
         logic [IDXW:0] sum;
         assign sum   = {1'b0, base_i} + {1'b0, ofs};
         assign idx_o = (sum >= (IDXW+1)'(NDESC)) ? IDXW'(sum - (IDXW+1)'(NDESC)) : sum[IDXW-1:0];
      end
   endgenerate
endmodule

// File: rtl/rxd_desc_table.sv
module rxd_desc_table
   import rxd_pkg::*;
#(
   parameter int NDESC = 8,
   parameter int OFFW  = 16,
   parameter int LENW  = 16,
   parameter int PORTW = 6,
   parameter int TSRW  = 28,
   parameter int TSFW  = 4,
   localparam int IDXW = $clog2(NDESC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_we,
   input  logic [IDXW-1:0]  sw_idx,
   input  logic [1:0]       sw_word,
   input  logic [31:0]      sw_wdata,
   input  logic [IDXW-1:0]  sw_rd_idx,
   input  logic [1:0]       sw_rd_word,
   output logic [31:0]      sw_rd_data,
   input  logic [IDXW-1:0]  hw_idx,
   output logic [OFFW-1:0]  hw_off,
   output logic [LENW-1:0]  hw_size,
   output logic [NDESC-1:0] empties,
   input  logic             wb_en,
   input  logic [IDXW-1:0]  wb_idx,
   input  logic             wb_err,
   input  logic [PORTW-1:0] wb_port,
   input  logic             wb_gotts,
   input  logic             wb_tsbad,
   input  logic [TSRW-1:0]  wb_rise,
   input  logic [TSFW-1:0]  wb_fall,
   input  logic [LENW-1:0]  wb_len
);
   logic [31:0] w0 [NDESC];
   logic [31:0] w1 [NDESC];
   logic [31:0] w2 [NDESC];
   logic [31:0] wb_w0;

   always_comb begin
      wb_w0                   = '0;
      wb_w0[W0_ERR]           = wb_err;
      wb_w0[W0_PORT +: PORTW] = wb_port;
      wb_w0[W0_GOTTS]         = wb_gotts;
      wb_w0[W0_TSBAD]         = wb_tsbad;
   end

   generate
      for (genvar gi = 0; gi < NDESC; gi++) begin : g_desc
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               w0[gi] <= '0;
               w1[gi] <= '0;
               w2[gi] <= '0;
            end else if (wb_en && wb_idx == IDXW'(gi)) begin
               w0[gi]           <= wb_w0;
               w1[gi]           <= {wb_fall, wb_rise};
               w2[gi][31:16]    <= 16'(wb_len);
            end else if (sw_we && sw_idx == IDXW'(gi)) begin
               case (sw_word)
                  WSEL_STAT: w0[gi] <= sw_wdata;
                  WSEL_TS:   w1[gi] <= sw_wdata;
                  WSEL_BUF:  w2[gi] <= sw_wdata;
                  default:   ;
               endcase
            end
         end
         assign empties[gi] = w0[gi][W0_EMPTY];
      end
   endgenerate

   always_comb begin
      case (sw_rd_word)
         WSEL_STAT: sw_rd_data = w0[sw_rd_idx];
         WSEL_TS:   sw_rd_data = w1[sw_rd_idx];
         WSEL_BUF:  sw_rd_data = w2[sw_rd_idx];
         default:   sw_rd_data = '0;
      endcase
   end

   assign hw_off  = w2[hw_idx][OFFW-1:0];
   assign hw_size = w2[hw_idx][16 +: LENW];
endmodule

// File: rtl/rx_desc_engine.sv
module rx_desc_engine
   import rxd_pkg::*;
#(
   parameter int NDESC = 8,
   parameter int DW    = 8,
   parameter int OFFW  = 16,
   parameter int LENW  = 16,
   parameter int PORTW = 6,
   parameter int TSRW  = 28,
   parameter int TSFW  = 4,
   localparam int IDXW = $clog2(NDESC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_enable,
   input  logic             in_valid,
   input  logic [DW-1:0]    in_data,
   input  logic             in_last,
   input  logic             in_err,
   input  logic [PORTW-1:0] in_port,
   input  logic             in_ts_valid,
   input  logic             in_ts_bad,
   input  logic [TSRW-1:0]  in_ts_rise,
   input  logic [TSFW-1:0]  in_ts_fall,
   output logic             ram_we,
   output logic [OFFW-1:0]  ram_addr,
   output logic [DW-1:0]    ram_wdata,
   input  logic             sw_we,
   input  logic [IDXW-1:0]  sw_idx,
   input  logic [1:0]       sw_word,
   input  logic [31:0]      sw_wdata,
   input  logic [IDXW-1:0]  sw_rd_idx,
   input  logic [1:0]       sw_rd_word,
   output logic [31:0]      sw_rd_data,
   input  logic             rec_clr,
   input  logic             bna_clr,
   input  logic             irq_ack,
   output logic             st_rec,
   output logic             st_bna,
   output logic             irq_rx,
   output logic [IDXW-1:0]  cur_desc
);
   // elaboration checks
   if (NDESC < 2)               begin : g_bad_ndesc $error("NDESC must be at least 2"); end
   if (OFFW > 16 || LENW > 16)  begin : g_bad_len   $error("offset and length fit 16 bits"); end
   if (OFFW < 3)                begin : g_bad_off   $error("offset needs word alignment bits"); end
   if (PORTW > 6)               begin : g_bad_port  $error("port field is 6 bits wide"); end
   if (TSRW + TSFW != 32)       begin : g_bad_ts    $error("timestamp must fill one word"); end

   rx_state_t       state_q;
   logic [IDXW-1:0] idx_q, next_q, pick_idx, act_idx;
   logic [LENW-1:0] cnt_q, cnt_now, act_size;
   logic [OFFW-1:0] act_off;
   logic [NDESC-1:0] empties;
   logic            err_q, found, first, take, nobuf, filling, room, err_now, done;

   assign first   = in_valid && (state_q == S_IDLE);
   assign take    = first && rx_enable && found;
   assign nobuf   = first && rx_enable && !found;
   assign act_idx = take ? pick_idx : idx_q;
   assign filling = take || (in_valid && state_q == S_FILL);
   assign cnt_now = take ? '0 : cnt_q;
   assign room    = cnt_now < act_size;
   assign err_now = (take ? 1'b0 : err_q) | in_err | !room;
   assign done    = filling && in_last;

   assign ram_we    = filling && room;
   assign ram_addr  = {act_off[OFFW-1:2], 2'b00} + OFFW'(cnt_now);
   assign ram_wdata = in_data;

   rxd_pick #(.NDESC(NDESC)) u_pick (
      .avail_i (empties),
      .base_i  (next_q),
      .found_o (found),
      .idx_o   (pick_idx)
   );

   rxd_desc_table #(
      .NDESC(NDESC), .OFFW(OFFW), .LENW(LENW),
      .PORTW(PORTW), .TSRW(TSRW), .TSFW(TSFW)
   ) u_tab (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_we      (sw_we),
      .sw_idx     (sw_idx),
      .sw_word    (sw_word),
      .sw_wdata   (sw_wdata),
      .sw_rd_idx  (sw_rd_idx),
      .sw_rd_word (sw_rd_word),
      .sw_rd_data (sw_rd_data),
      .hw_idx     (act_idx),
      .hw_off     (act_off),
      .hw_size    (act_size),
      .empties    (empties),
      .wb_en      (done),
      .wb_idx     (act_idx),
      .wb_err     (err_now),
      .wb_port    (in_port),
      .wb_gotts   (in_ts_valid),
      .wb_tsbad   (in_ts_bad),
      .wb_rise    (in_ts_rise),
      .wb_fall    (in_ts_fall),
      .wb_len     (cnt_now + LENW'(room))
   );

   logic [2:0] fl_set, fl_clr, fl_q;
   assign fl_set = {done, done, nobuf};
   assign fl_clr = {irq_ack, rec_clr, bna_clr};
   generate
      for (genvar gf = 0; gf < 3; gf++) begin : g_flag
         rxd_flag u_flag (.clk(clk), .rst_n(rst_n), .set_i(fl_set[gf]), .clr_i(fl_clr[gf]), .q_o(fl_q[gf]));
      end
   endgenerate
   assign st_bna = fl_q[0];
   assign st_rec = fl_q[1];
   assign irq_rx = fl_q[2];
   assign cur_desc = idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         next_q  <= '0;
         cnt_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         if (take) begin
            idx_q  <= pick_idx;
            next_q <= pick_idx + 1'b1;
         end
         if (filling) begin
            cnt_q <= cnt_now + LENW'(room);
            err_q <= err_now;
         end
         case (state_q)
            S_IDLE: if (in_valid && !in_last) state_q <= take ? S_FILL : S_DROP;
            S_FILL, S_DROP: if (in_valid && in_last) state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxd_chk.sv
module rxd_chk #(
   parameter int IDXW = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            in_last,
   input logic            ram_we,
   input logic            rec_clr,
   input logic            irq_ack,
   input logic            st_rec,
   input logic            st_bna,
   input logic            irq_rx,
   input logic [IDXW-1:0] cur_desc
);
   // R3
   ram_we_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> in_valid);
   // R8
   bna_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_bna) |-> $past(in_valid));
   // R10
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_rx) |-> $past(in_valid && in_last));
   // R9
   rec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_clr && !(in_valid && in_last)) |=> !st_rec);
   // R10
   irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !(in_valid && in_last)) |=> !irq_rx);
   // R12
   cur_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_desc) |-> $past(in_valid));
endmodule

bind rx_desc_engine rxd_chk #(.IDXW(IDXW)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
   .ram_we(ram_we), .rec_clr(rec_clr), .irq_ack(irq_ack),
   .st_rec(st_rec), .st_bna(st_bna), .irq_rx(irq_rx), .cur_desc(cur_desc)
);

// File: tb/rx_desc_engine_bench.sv
`timescale 1ns/1ps
module rx_desc_engine_bench;
   logic clk = 0, rst_n = 0;
   logic rx_enable = 0, in_valid = 0, in_last = 0, in_err = 0;
   logic [7:0] in_data = 0;
   logic [5:0] in_port = 0;
   logic in_ts_valid = 0, in_ts_bad = 0;
   logic [27:0] in_ts_rise = 0;
   logic [3:0]  in_ts_fall = 0;
   logic ram_we;
   logic [15:0] ram_addr;
   logic [7:0]  ram_wdata;
   logic sw_we = 0;
   logic [2:0] sw_idx = 0, sw_rd_idx = 0;
   logic [1:0] sw_word = 0, sw_rd_word = 0;
   logic [31:0] sw_wdata = 0, sw_rd_data;
   logic rec_clr = 0, bna_clr = 0, irq_ack = 0;
   logic st_rec, st_bna, irq_rx;
   logic [2:0] cur_desc;

   int nchk = 0, nfail = 0;
   bit finished = 0;
   logic [23:0] expq [$];

   always #10 clk = ~clk;

   rx_desc_engine u_rx_desc_engine (.*);

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor: every RAM write must match the head of the queue
   always @(negedge clk) if (rst_n && ram_we) begin
      if (expq.size() == 0) check(0, "R3 unexpected RAM write", {ram_addr, ram_wdata}, 0);
      else begin
         logic [23:0] e;
         e = expq.pop_front();
         check({ram_addr, ram_wdata} == e, "R3 RAM write", {ram_addr, ram_wdata}, e);
      end
   end

   task automatic sw_write(input int idx, input int word, input logic [31:0] d);
      @(posedge clk); #1;
      sw_we = 1; sw_idx = 3'(idx); sw_word = 2'(word); sw_wdata = d;
      @(posedge clk); #1;
      sw_we = 0;
   endtask

   task automatic rd(input int idx, input int word, output logic [31:0] d);
      sw_rd_idx = 3'(idx); sw_rd_word = 2'(word);
      #1 d = sw_rd_data;
   endtask

   task automatic pulse(ref logic s);
      @(posedge clk); #1 s = 1;
      @(posedge clk); #1 s = 0;
   endtask

   // driver: pushes expected writes, then plays the beats
   task automatic send_frame(input int n, input int errpos, input logic [5:0] port,
                             input bit tsv, input bit tsb, input logic [27:0] rise,
                             input logic [3:0] fall, input logic [7:0] seed,
                             input bit wr, input logic [15:0] base, input int size);
      if (wr) for (int i = 0; i < n && i < size; i++)
         expq.push_back({16'(base + 16'(i)), 8'(seed + 8'(i))});
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         in_valid = 1; in_data = seed + 8'(i); in_last = (i == n - 1);
         in_err = (i == errpos);
         in_port = port; in_ts_valid = tsv; in_ts_bad = tsb;
         in_ts_rise = rise; in_ts_fall = fall;
      end
      @(posedge clk); #1;
      in_valid = 0; in_last = 0; in_err = 0;
      @(negedge clk);
      check(expq.size() == 0, "R3 all bytes written", expq.size(), 0);
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         check(0, "watchdog", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(!st_rec && !st_bna && !irq_rx, "R1 flags", {st_rec, st_bna, irq_rx}, 0);
      check(cur_desc == 0 && !ram_we, "R1 cur_desc/ram_we", {cur_desc, ram_we}, 0);
      rd(3, 0, d); check(d == 0, "R1 desc word0", d, 0);

      // arm descriptors 0,1,2,5
      sw_write(0, 2, {16'd16, 16'h0100}); sw_write(0, 0, 1);
      sw_write(1, 2, {16'd16, 16'h0203}); sw_write(1, 0, 1);
      sw_write(2, 2, {16'd4,  16'h0300}); sw_write(2, 0, 1);
      sw_write(5, 2, {16'd16, 16'h0500}); sw_write(5, 0, 1);
      rx_enable = 1;

      // frame A -> desc 0
      send_frame(6, -1, 6'd5, 1, 0, 28'h0ABCDEF, 4'h9, 8'h10, 1, 16'h0100, 16);
      rd(0, 0, d); check(d == 32'h4500, "R4 R5 desc0 word0", d, 32'h4500);
      rd(0, 1, d); check(d == 32'h90ABCDEF, "R5 desc0 timestamp", d, 32'h90ABCDEF);
      rd(0, 2, d); check(d == 32'h00060100, "R4 desc0 length", d, 32'h00060100);
      check(st_rec && irq_rx, "R9 R10 flags set", {st_rec, irq_rx}, 2'b11);
      check(cur_desc == 0, "R12 cur_desc A", cur_desc, 0);
      pulse(irq_ack); @(negedge clk);
      check(!irq_rx && st_rec, "R10 ack only irq", {st_rec, irq_rx}, 2'b10);
      pulse(rec_clr); @(negedge clk);
      check(!st_rec, "R9 rec cleared", st_rec, 0);

      // frame B -> desc 1, error mid-frame, misaligned offset
      send_frame(5, 2, 6'd63, 1, 1, 28'h1234567, 4'h3, 8'h40, 1, 16'h0200, 16);
      rd(1, 0, d); check(d == 32'hFF02, "R6 R5 desc1 word0", d, 32'hFF02);
      rd(1, 2, d); check(d == 32'h00050203, "R4 desc1 offset kept", d, 32'h00050203);
      check(cur_desc == 1, "R12 cur_desc B", cur_desc, 1);

      // frame C -> desc 2, overflow
      send_frame(7, -1, 6'd2, 0, 0, 28'h0, 4'h0, 8'h80, 1, 16'h0300, 4);
      rd(2, 0, d); check(d == 32'h0202, "R7 desc2 error", d, 32'h0202);
      rd(2, 2, d); check(d == 32'h00040300, "R7 desc2 truncated len", d, 32'h00040300);
      pulse(rec_clr); pulse(irq_ack); @(negedge clk);

      // disabled frame: ignored
      rx_enable = 0;
      send_frame(3, -1, 6'd7, 0, 0, 28'h0, 4'h0, 8'hA0, 0, 16'h0, 0);
      check(!st_rec && !st_bna && !irq_rx, "R11 no flags", {st_rec, st_bna, irq_rx}, 0);
      check(cur_desc == 2, "R11 cur_desc kept", cur_desc, 2);
      rd(5, 0, d); check(d == 1, "R11 desc5 untouched", d, 1);
      rx_enable = 1;

      // frame D -> desc 5 (3,4 skipped)
      send_frame(3, -1, 6'd1, 0, 0, 28'h0, 4'h0, 8'hC0, 1, 16'h0500, 16);
      check(cur_desc == 5, "R2 skip to desc5", cur_desc, 5);
      rd(5, 2, d); check(d == 32'h00030500, "R4 desc5 length", d, 32'h00030500);
      rd(5, 0, d); check(d == 32'h0100, "R5 desc5 port", d, 32'h0100);
      pulse(rec_clr); pulse(irq_ack); @(negedge clk);

      // frame E: nothing free
      send_frame(4, -1, 6'd0, 0, 0, 28'h0, 4'h0, 8'hE0, 0, 16'h0, 0);
      check(st_bna, "R8 bna set", st_bna, 1);
      check(!st_rec && cur_desc == 5, "R8 R13 no completion", {st_rec, cur_desc}, 4'h5);
      rd(0, 0, d); check(d == 32'h4500, "R13 desc0 not reused", d, 32'h4500);
      pulse(bna_clr); @(negedge clk);
      check(!st_bna, "R8 bna cleared", st_bna, 0);

      // re-arm desc 0 only: single-beat frame wraps from 6 to 0
      sw_write(0, 2, {16'd16, 16'h0100}); sw_write(0, 0, 1);
      send_frame(1, -1, 6'd9, 0, 0, 28'h0, 4'h0, 8'h55, 1, 16'h0100, 16);
      check(cur_desc == 0, "R2 wrap to desc0", cur_desc, 0);
      rd(0, 2, d); check(d == 32'h00010100, "R4 single beat len", d, 32'h00010100);
      rd(1, 0, d); check(d == 32'hFF02, "R13 desc1 untouched", d, 32'hFF02);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule